// File: doc/BRIEF.md
# Ternary Associative Pattern Bank

This block is a small associative memory for track-finding style pattern recognition. It holds a number of patterns, and each pattern has eight layers. Each layer stores a 15-bit word. The three least significant bits of that word can each be marked don't-care, so a single stored layer can match at coarse or at fine resolution. On every clock, each layer takes a word from its own hit bus and compares it with the stored word of that layer in every pattern at once.

A layer that matches any hit stays flagged until the event is cleared by the event-init input. Each pattern counts its flagged layers and compares the count with a programmable miss budget. The pattern then reports a match, subject to four further controls: an optional demand that layer 0 has fired, a per-pattern disable flip-flop, a force-read override and a global read block. The per-pattern map of fired layers is output beside the match vector, so a reader can attach it to the identity of each pattern.

Patterns are loaded one layer at a time through a write port that takes one cycle per write.

Top module: `tern_pattern_bank`

## Requirements
- R1: After synchronous reset, `match_vec` and `fired_map` are all zero, every stored word and don't-care mask is zero, and every pattern is enabled.
- R2: When `wr_en` is high at a rising edge, the stored word of pattern `wr_pat`, layer `wr_layer`, takes `wr_value` and its mask takes `wr_dcmask`. Hits in that same cycle are compared against the old contents.
- R3: A layer matches a hit word when the upper 12 bits are equal and, for each of bits 2..0, the bits are equal or the matching bit of the stored mask is 1. A mask of 0 demands full-resolution equality.
- R4: A valid hit that matches sets the flag of that layer, and the flag stays set until `evt_init`. When `evt_init` is high at an edge, every flag clears and hits in that cycle are dropped. `fired_map[p*8+l]` is the flag of layer l of pattern p.
- R5: `thr_mode` selects the miss budget: 0 means no pattern matches by count, 1 means all 8 layers, 2 means at least 7 layers, 3 means at least 6 layers.
- R6: While `need_layer0` is high, a pattern reports by count only if its layer 0 flag is set.
- R7: A strobe on `dis_we` sets the disable bit of pattern `dis_pat` when `dis_set` is 1, else clears it when `dis_clr` is 1, else leaves it alone. A disabled pattern never reports.
- R8: `force_read` reports every enabled pattern regardless of flags, miss budget and `need_layer0`.
- R9: `block_read` suppresses all reporting, even under `force_read`.
- R10: The hits, configuration and disable state at edge t produce `match_vec` and `fired_map` just after that same edge, through one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_init | input | 1 | Clear all layer flags (event boundary) |
| hit_valid | input | 8 | Per-layer hit valid |
| hit_word | input | 120 | Per-layer hit words, layer l at bits [l*15 +: 15] |
| wr_en | input | 1 | Pattern layer write strobe |
| wr_pat | input | 3 | Pattern index to write |
| wr_layer | input | 3 | Layer index to write |
| wr_value | input | 15 | Stored word |
| wr_dcmask | input | 3 | Don't-care mask for bits 2..0 |
| dis_we | input | 1 | Disable bit write line |
| dis_pat | input | 3 | Pattern whose disable bit is written |
| dis_set | input | 1 | Set the disable bit |
| dis_clr | input | 1 | Clear the disable bit |
| thr_mode | input | 2 | Miss budget select |
| need_layer0 | input | 1 | Demand layer 0 for count-based reports |
| force_read | input | 1 | Report all enabled patterns |
| block_read | input | 1 | Suppress all reports |
| match_vec | output | 8 | Registered matched-pattern vector |
| fired_map | output | 64 | Per-pattern fired-layer map |

## Verification
The bench aims at the edges of the ternary compare: a difference in a masked low bit must still match, a difference in an unmasked low bit or in any upper bit must not, and a design that applied the mask to the wrong bits would flag the wrong layers. It checks that a hit arriving in the same cycle as the event init is dropped and that flags persist across idle cycles; a non-sticky or init-losing flag shows up as a wrong fired map. The seven-of-eight and six-of-eight budgets are exercised at exactly the boundary count. The layer 0 demand, the set-wins disable strobe and the priority of block over force are each driven directly, because a swapped priority changes the match vector at once.

// File: rtl/tpb_pkg.sv
package tpb_pkg;

    localparam int TPB_WORD_W  = 15;
    localparam int TPB_DC_W    = 3;
    localparam int TPB_LAYERS  = 8;
    localparam int TPB_PATTERNS = 8;

    typedef enum logic [1:0] {
        THR_OFF   = 2'd0,
        THR_MISS0 = 2'd1,
        THR_MISS1 = 2'd2,
        THR_MISS2 = 2'd3
    } thr_mode_e;

    typedef struct packed {
        thr_mode_e mode;
        logic      need_l0;
        logic      force_rd;
        logic      block_rd;
    } rd_cfg_t;

    typedef struct packed {
        logic we;
        logic set;
        logic clr;
    } dis_cmd_t;

    // Ternary compare: low DC_W bits may be masked, the rest must be equal.
    function automatic logic tern_hit(
        input logic [TPB_WORD_W-1:0] hit,
        input logic [TPB_WORD_W-1:0] stored,
        input logic [TPB_DC_W-1:0]   dc
    );
        logic [TPB_WORD_W-1:0] care;
        care = ~{{(TPB_WORD_W-TPB_DC_W){1'b0}}, dc};
        return ~|((hit ^ stored) & care);
    endfunction

endpackage

// File: rtl/tpb_layer_cell.sv
module tpb_layer_cell
    import tpb_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  init,
    input  logic                  wr_en,
    input  logic [TPB_WORD_W-1:0] wr_value,
    input  logic [TPB_DC_W-1:0]   wr_dc,
    input  logic                  hit_valid,
    input  logic [TPB_WORD_W-1:0] hit_word,
    output logic                  flag_nxt,
    output logic                  flag_q
);
    logic [TPB_WORD_W-1:0] word_q;
    logic [TPB_DC_W-1:0]   dc_q;
    logic                  hit_now;

    assign hit_now  = hit_valid && tern_hit(hit_word, word_q, dc_q);
    assign flag_nxt = init ? 1'b0 : (flag_q | hit_now);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            dc_q   <= '0;
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_nxt;
            if (wr_en) begin
                word_q <= wr_value;
                dc_q   <= wr_dc;
            end
        end
    end

    p_flag_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !init) |=> flag_q);
    p_init_clears_r4: assert property (@(posedge clk) disable iff (rst)
        init |=> !flag_q);

endmodule

// File: rtl/tpb_majority.sv
module tpb_majority
    import tpb_pkg::*;
#(
    parameter int NUM_LAYER = TPB_LAYERS
) (
    input  logic [NUM_LAYER-1:0] flags,
    input  rd_cfg_t              cfg,
    input  logic                 disabled,
    output logic                 report
);
    localparam int CW = $clog2(NUM_LAYER + 1);

    logic [CW-1:0] cnt;
    logic          count_ok;
    logic          l0_ok;

    always_comb begin
        cnt = '0;
        for (int i = 0; i < NUM_LAYER; i++) begin
            cnt = cnt + CW'(flags[i]);
        end
    end

    always_comb begin
        unique case (cfg.mode)
            THR_MISS0: count_ok = (cnt == CW'(NUM_LAYER));
            THR_MISS1: count_ok = (cnt >= CW'(NUM_LAYER - 1));
            THR_MISS2: count_ok = (cnt >= CW'(NUM_LAYER - 2));
            default:   count_ok = 1'b0;
        endcase
    end

    assign l0_ok  = !cfg.need_l0 || flags[0];
    assign report = !disabled && !cfg.block_rd &&
                    (cfg.force_rd || (count_ok && l0_ok));

endmodule

// File: rtl/tpb_row.sv
module tpb_row
    import tpb_pkg::*;
#(
    parameter int NUM_LAYER = TPB_LAYERS,
    localparam int LW = $clog2(NUM_LAYER)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            init,
    input  logic [NUM_LAYER-1:0]            hit_valid,
    input  logic [NUM_LAYER*TPB_WORD_W-1:0] hit_word,
    input  logic                            wr_en,
    input  logic [LW-1:0]                   wr_layer,
    input  logic [TPB_WORD_W-1:0]           wr_value,
    input  logic [TPB_DC_W-1:0]             wr_dc,
    input  dis_cmd_t                        dis_cmd,
    input  rd_cfg_t                         cfg,
    output logic                            match_q,
    output logic [NUM_LAYER-1:0]            flags_q
);
    logic [NUM_LAYER-1:0] flags_nxt;
    logic                 dis_q;
    logic                 dis_nxt;
    logic                 report;

    for (genvar g = 0; g < NUM_LAYER; g++) begin : g_layer
        tpb_layer_cell u_cell (
            .clk       (clk),
            .rst       (rst),
            .init      (init),
            .wr_en     (wr_en && (wr_layer == LW'(g))),
            .wr_value  (wr_value),
            .wr_dc     (wr_dc),
            .hit_valid (hit_valid[g]),
            .hit_word  (hit_word[g*TPB_WORD_W +: TPB_WORD_W]),
            .flag_nxt  (flags_nxt[g]),
            .flag_q    (flags_q[g])
        );
    end

    always_comb begin
        dis_nxt = dis_q;
        if (dis_cmd.we) begin
            if (dis_cmd.set)      dis_nxt = 1'b1;
            else if (dis_cmd.clr) dis_nxt = 1'b0;
        end
    end

    tpb_majority #(.NUM_LAYER(NUM_LAYER)) u_maj (
        .flags    (flags_nxt),
        .cfg      (cfg),
        .disabled (dis_nxt),
        .report   (report)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dis_q   <= 1'b0;
            match_q <= 1'b0;
        end else begin
            dis_q   <= dis_nxt;
            match_q <= report;
        end
    end

    p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        dis_q |-> !match_q);
    p_block_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        cfg.block_rd |=> !match_q);
    p_mode_off_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == THR_OFF && !cfg.force_rd) |=> !match_q);
    p_all_layers_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == THR_MISS0 && !cfg.force_rd) |=> (!match_q || (&flags_q)));
    p_layer0_needed_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg.need_l0 && !cfg.force_rd) |=> (!match_q || flags_q[0]));

endmodule

// File: rtl/tern_pattern_bank.sv
module tern_pattern_bank
    import tpb_pkg::*;
#(
    parameter int NUM_PAT   = TPB_PATTERNS,
    parameter int NUM_LAYER = TPB_LAYERS,
    localparam int PW = $clog2(NUM_PAT),
    localparam int LW = $clog2(NUM_LAYER)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            evt_init,
    input  logic [NUM_LAYER-1:0]            hit_valid,
    input  logic [NUM_LAYER*TPB_WORD_W-1:0] hit_word,
    input  logic                            wr_en,
    input  logic [PW-1:0]                   wr_pat,
    input  logic [LW-1:0]                   wr_layer,
    input  logic [TPB_WORD_W-1:0]           wr_value,
    input  logic [TPB_DC_W-1:0]             wr_dcmask,
    input  logic                            dis_we,
    input  logic [PW-1:0]                   dis_pat,
    input  logic                            dis_set,
    input  logic                            dis_clr,
    input  logic [1:0]                      thr_mode,
    input  logic                            need_layer0,
    input  logic                            force_read,
    input  logic                            block_read,
    output logic [NUM_PAT-1:0]              match_vec,
    output logic [NUM_PAT*NUM_LAYER-1:0]    fired_map
);
    rd_cfg_t cfg;

    assign cfg.mode     = thr_mode_e'(thr_mode);
    assign cfg.need_l0  = need_layer0;
    assign cfg.force_rd = force_read;
    assign cfg.block_rd = block_read;

    for (genvar p = 0; p < NUM_PAT; p++) begin : g_pat
        dis_cmd_t cmd;
        assign cmd.we  = dis_we && (dis_pat == PW'(p));
        assign cmd.set = dis_set;
        assign cmd.clr = dis_clr;

        tpb_row #(.NUM_LAYER(NUM_LAYER)) u_row (
            .clk       (clk),
            .rst       (rst),
            .init      (evt_init),
            .hit_valid (hit_valid),
            .hit_word  (hit_word),
            .wr_en     (wr_en && (wr_pat == PW'(p))),
            .wr_layer  (wr_layer),
            .wr_value  (wr_value),
            .wr_dc     (wr_dcmask),
            .dis_cmd   (cmd),
            .cfg       (cfg),
            .match_q   (match_vec[p]),
            .flags_q   (fired_map[p*NUM_LAYER +: NUM_LAYER])
        );
    end

    p_block_all_r9: assert property (@(posedge clk) disable iff (rst)
        block_read |=> (match_vec == '0));

endmodule

// File: tb/tern_pattern_bank_bench.sv
module tern_pattern_bank_bench;
    localparam int NP = 8;
    localparam int NL = 8;
    localparam int W  = 15;

    logic clk = 1'b0;
    logic rst;
    logic evt_init;
    logic [NL-1:0] hit_valid;
    logic [NL*W-1:0] hit_word;
    logic wr_en;
    logic [2:0] wr_pat, wr_layer, dis_pat;
    logic [W-1:0] wr_value;
    logic [2:0] wr_dcmask;
    logic dis_we, dis_set, dis_clr;
    logic [1:0] thr_mode;
    logic need_layer0, force_read, block_read;
    logic [NP-1:0] match_vec;
    logic [NP*NL-1:0] fired_map;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [W-1:0] m_word [NP][NL];
    logic [2:0]   m_dc   [NP][NL];
    logic [NL-1:0] m_flag [NP];
    logic [NP-1:0] m_dis;
    logic [NP-1:0] m_match;

    always #5 clk = ~clk;

    tern_pattern_bank u_tern_pattern_bank (
        .clk(clk), .rst(rst), .evt_init(evt_init), .hit_valid(hit_valid),
        .hit_word(hit_word), .wr_en(wr_en), .wr_pat(wr_pat), .wr_layer(wr_layer),
        .wr_value(wr_value), .wr_dcmask(wr_dcmask), .dis_we(dis_we),
        .dis_pat(dis_pat), .dis_set(dis_set), .dis_clr(dis_clr),
        .thr_mode(thr_mode), .need_layer0(need_layer0), .force_read(force_read),
        .block_read(block_read), .match_vec(match_vec), .fired_map(fired_map)
    );

    function automatic bit ref_hit(logic [W-1:0] h, logic [W-1:0] s, logic [2:0] dc);
        for (int b = 0; b < W; b++) begin
            if (b < 3 && dc[b]) continue;
            if (h[b] != s[b]) return 0;
        end
        return 1;
    endfunction

    function automatic bit ref_report(logic [NL-1:0] f, bit dis);
        int c;
        bit ok;
        c = $countones(f);
        case (thr_mode)
            2'd1: ok = (c == 8);
            2'd2: ok = (c >= 7);
            2'd3: ok = (c >= 6);
            default: ok = 0;
        endcase
        if (need_layer0 && !f[0]) ok = 0;
        return !dis && !block_read && (force_read || ok);
    endfunction

    task automatic check(string tag, logic [127:0] got, logic [127:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic tick(string tag);
        logic [NL-1:0] nf [NP];
        logic [NP-1:0] nd;
        logic [NP*NL-1:0] emap;
        for (int p = 0; p < NP; p++) begin
            for (int l = 0; l < NL; l++) begin
                bit h;
                h = hit_valid[l] && ref_hit(hit_word[l*W +: W], m_word[p][l], m_dc[p][l]);
                nf[p][l] = evt_init ? 1'b0 : (m_flag[p][l] | h);
            end
            nd[p] = m_dis[p];
            if (dis_we && dis_pat == 3'(p)) begin
                if (dis_set) nd[p] = 1'b1;
                else if (dis_clr) nd[p] = 1'b0;
            end
        end
        for (int p = 0; p < NP; p++) begin
            m_match[p] = ref_report(nf[p], nd[p]);
            m_flag[p] = nf[p];
        end
        m_dis = nd;
        if (wr_en) begin
            m_word[wr_pat][wr_layer] = wr_value;
            m_dc[wr_pat][wr_layer]   = wr_dcmask;
        end
        @(posedge clk);
        #1;
        for (int p = 0; p < NP; p++) emap[p*NL +: NL] = m_flag[p];
        check({tag, " match"}, 128'(match_vec), 128'(m_match));
        check({tag, " map"}, 128'(fired_map), 128'(emap));
    endtask

    task automatic idle();
        evt_init = 0; hit_valid = '0; hit_word = '0; wr_en = 0;
        wr_pat = '0; wr_layer = '0; wr_value = '0; wr_dcmask = '0;
        dis_we = 0; dis_pat = '0; dis_set = 0; dis_clr = 0;
        force_read = 0; block_read = 0;
    endtask

    task automatic hits_of(int p, logic [NL-1:0] lm);
        hit_valid = lm;
        for (int l = 0; l < NL; l++) hit_word[l*W +: W] = m_word[p][l];
    endtask

    task automatic write(int p, int l, logic [W-1:0] v, logic [2:0] dc, string tag);
        wr_en = 1; wr_pat = 3'(p); wr_layer = 3'(l); wr_value = v; wr_dcmask = dc;
        tick(tag);
        wr_en = 0;
    endtask

    task automatic dis_op(int p, bit s, bit c, string tag);
        dis_we = 1; dis_pat = 3'(p); dis_set = s; dis_clr = c;
        tick(tag);
        dis_we = 0; dis_set = 0; dis_clr = 0;
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        idle();
        thr_mode = 2'd0; need_layer0 = 0;
        for (int p = 0; p < NP; p++) begin
            m_flag[p] = '0;
            for (int l = 0; l < NL; l++) begin m_word[p][l] = '0; m_dc[p][l] = '0; end
        end
        m_dis = '0; m_match = '0;
        rst = 1;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1: reset state at the ports
        check("R1 match", 128'(match_vec), 128'(0));
        check("R1 map", 128'(fired_map), 128'(0));

        // R2: load patterns, hits same cycle see old words
        for (int p = 0; p < NP; p++)
            for (int l = 0; l < NL; l++)
                write(p, l, 15'((p << 8) | (l << 4) | 3), 3'b000, "R2");
        thr_mode = 2'd1;
        hits_of(0, 8'hFF);
        tick("R2 all layers");
        hits_of(1, 8'hFF);
        write(1, 2, 15'h7777, 3'b000, "R2 write during hit");
        hit_valid = '0;
        evt_init = 1; tick("R4 init"); evt_init = 0;

        // R3: ternary low bits
        write(2, 0, 15'h00A8, 3'b011, "R3 load");
        hit_valid = 8'h01; hit_word = '0; hit_word[W-1:0] = 15'h00AB;
        tick("R3 masked bits differ");
        evt_init = 1; hit_valid = '0; tick("R3 clear"); evt_init = 0;
        hit_valid = 8'h01; hit_word[W-1:0] = 15'h00AC;
        tick("R3 unmasked bit2 differs");
        hit_word[W-1:0] = 15'h10A8;
        tick("R3 upper bit differs");
        write(2, 0, 15'h00A8, 3'b000, "R3 fine");
        hit_valid = 8'h01; hit_word[W-1:0] = 15'h00A9;
        tick("R3 fine resolution miss");
        hit_word[W-1:0] = 15'h00A8;
        tick("R3 fine resolution hit");
        hit_valid = '0;

        // R4: sticky, init drops same-cycle hits
        evt_init = 1; tick("R4 clear"); evt_init = 0;
        hits_of(3, 8'h0F); tick("R4 partial");
        hit_valid = '0; tick("R4 hold"); tick("R4 hold2");
        hits_of(3, 8'hF0); evt_init = 1; tick("R4 init drops hit"); evt_init = 0;
        hit_valid = '0; tick("R4 after init");

        // R5: budgets at boundary
        thr_mode = 2'd3; hits_of(4, 8'h3F); tick("R5 six of eight");
        evt_init = 1; hit_valid = '0; tick("R5 clear"); evt_init = 0;
        thr_mode = 2'd2; hits_of(4, 8'h3F); tick("R5 six under seven");
        hits_of(4, 8'h40); tick("R5 seven");
        thr_mode = 2'd1; hit_valid = '0; tick("R5 seven under eight");
        thr_mode = 2'd0; hits_of(4, 8'h80); tick("R5 off with eight");
        thr_mode = 2'd1; hit_valid = '0; tick("R5 eight");
        evt_init = 1; tick("R5 clear2"); evt_init = 0;

        // R6: layer0 demand
        thr_mode = 2'd2; need_layer0 = 1;
        hits_of(5, 8'hFE); tick("R6 no layer0");
        hits_of(5, 8'h01); tick("R6 layer0 arrives");
        need_layer0 = 0;

        // R7: disable strobe
        hit_valid = '0;
        dis_op(5, 1, 0, "R7 set");
        dis_op(5, 1, 1, "R7 set wins");
        tick("R7 stays off");
        dis_op(5, 0, 0, "R7 neither");
        dis_op(5, 0, 1, "R7 clear");

        // R8 / R9
        thr_mode = 2'd0; need_layer0 = 1; force_read = 1;
        dis_op(6, 1, 0, "R8 force with disabled");
        block_read = 1; tick("R9 block over force");
        force_read = 0; thr_mode = 2'd2; tick("R9 block over count");
        block_read = 0; need_layer0 = 0; tick("R9 released");
        dis_op(6, 0, 1, "R8 reenable");

        // R10: random traffic, expectations one register after the edge
        for (int i = 0; i < 4000; i++) begin
            int tp;
            idle();
            tp = $urandom_range(NP - 1);
            if ($urandom_range(29) == 0) evt_init = 1;
            if ($urandom_range(49) == 0) thr_mode = 2'($urandom);
            need_layer0 = ($urandom_range(7) == 0);
            force_read  = ($urandom_range(40) == 0);
            block_read  = ($urandom_range(40) == 0);
            for (int l = 0; l < NL; l++) begin
                logic [W-1:0] w;
                w = ($urandom_range(3) != 0) ? m_word[tp][l] : W'($urandom);
                hit_word[l*W +: W] = w ^ W'($urandom_range(7) & ($urandom_range(1) ? 7 : 0));
            end
            hit_valid = NL'($urandom);
            if ($urandom_range(15) == 0) begin
                wr_en = 1; wr_pat = 3'($urandom); wr_layer = 3'($urandom);
                wr_value = W'($urandom); wr_dcmask = 3'($urandom);
            end
            if ($urandom_range(31) == 0) begin
                dis_we = 1; dis_pat = 3'($urandom); dis_set = 1'($urandom); dis_clr = 1'($urandom);
            end
            tick("R10 random");
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired got hang expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule